// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It catches the one case that forwarding cannot cover: the instruction being decoded reads a register that the instruction one stage ahead, in execute, is still loading from memory. When that happens the unit freezes the program counter and the fetch/decode register for one cycle. It also turns the entry written into the decode/execute register into a no-op bubble by clearing every control field.

The unit is purely combinational. Its inputs are the memory-read flag and destination register of the instruction in execute, the two source register numbers of the instruction in decode, and the control word produced by the decoder. It returns the two write enables for the front of the pipeline and the control word to latch into decode/execute. The datapath fields of that register are outside this block and keep flowing unchanged. After a stall, the bubble carries no memory read, so the next cycle cannot stall again on the same pair, and the loaded value then arrives through the later forwarding path.

Top module: `load_use_hazard`

## Requirements
- R1: A stall is raised when `exMemRead` is 1, `exRt` is nonzero and `exRt` equals `idRs`.
- R2: A stall is raised when `exMemRead` is 1, `exRt` is nonzero and `exRt` equals `idRt`.
- R3: With `exMemRead` at 0 no stall is raised, whatever the register numbers are.
- R4: With `exRt` equal to 0 (the hardwired zero register) no stall is raised, even if a source matches.
- R5: With `exMemRead` at 1 and `exRt` equal to neither source, no stall is raised.
- R6: During a stall `pcWrite` and `ifidWrite` are both 0. Otherwise both are 1.
- R7: During a stall `idexCtrl` is all zeros. This includes regWrite (bit 0) and memWrite (bit 2).
- R8: Without a stall `idexCtrl` equals `decCtrl` bit for bit. The control word layout is, from MSB: bit 8 regDst, bit 7 aluSrc, bits 6:5 aluOp, bit 4 branch, bit 3 memRead, bit 2 memWrite, bit 1 memToReg, bit 0 regWrite.
- R9: A stall lasts one cycle per load-use pair. The bubble's memRead (bit 3 of `idexCtrl`) is 0, so when it reaches execute the same decode instruction proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exMemRead | input | 1 | Memory-read flag of the instruction in execute |
| exRt | input | REG_ADDR_W | Load destination register of the instruction in execute |
| idRs | input | REG_ADDR_W | First source register of the instruction in decode |
| idRt | input | REG_ADDR_W | Second source register of the instruction in decode |
| decCtrl | input | 9 | Control word from the decoder |
| pcWrite | output | 1 | Program counter write enable |
| ifidWrite | output | 1 | Fetch/decode register write enable |
| idexCtrl | output | 9 | Control word to latch into decode/execute |

## Verification
There is no register between any input and any output, so every result is due in the same cycle as its stimulus. The bench drives inputs just after a rising edge and samples at the following falling edge, once the logic has settled. The one-cycle stall length is checked across cycles: a small model of the decode/execute control stage feeds the bubble's memRead back in as the next `exMemRead`, and the bench expects the front end to be released in that next cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int ALUOP_W = 2;

  typedef struct packed {
    logic               regDst;
    logic               aluSrc;
    logic [ALUOP_W-1:0] aluOp;
    logic               branch;
    logic               memRead;
    logic               memWrite;
    logic               memToReg;
    logic               regWrite;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // strobes from detection control to the gating datapath
  typedef struct packed {
    logic bubble;     // clear control fields headed for ID/EX
    logic holdFront;  // freeze PC and IF/ID
  } strobe_t;
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic                  exMemRead,
  input  logic [REG_ADDR_W-1:0] exRt,
  input  logic [REG_ADDR_W-1:0] idSrc [NUM_SRC],
  output strobe_t               strobes
);
  logic [NUM_SRC-1:0] srcHit;
  logic               loadLive;
  logic               stall;

  // a load into the zero register never produces a value worth waiting for
  assign loadLive = exMemRead && (exRt != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = (idSrc[s] == exRt);
  end

  assign stall = loadLive && (|srcHit);

  always_comb begin
    strobes.bubble    = stall;
    strobes.holdFront = stall;
  end
endmodule

// File: rtl/hazard_dp.sv
module hazard_dp
  import hazard_pkg::*;
(
  input  strobe_t strobes,
  input  ctrl_t   decCtrl,
  output logic    pcWrite,
  output logic    ifidWrite,
  output ctrl_t   idexCtrl
);
  assign pcWrite   = !strobes.holdFront;
  assign ifidWrite = !strobes.holdFront;

  always_comb begin
    idexCtrl = decCtrl;
    if (strobes.bubble) begin
      idexCtrl = '0;
    end
  end
endmodule

// File: rtl/load_use_hazard.sv
module load_use_hazard
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  exMemRead,
  input  logic [REG_ADDR_W-1:0] exRt,
  input  logic [REG_ADDR_W-1:0] idRs,
  input  logic [REG_ADDR_W-1:0] idRt,
  input  logic [CTRL_W-1:0]     decCtrl,
  output logic                  pcWrite,
  output logic                  ifidWrite,
  output logic [CTRL_W-1:0]     idexCtrl
);
  localparam int NUM_SRC = 2;

  logic [REG_ADDR_W-1:0] idSrc [NUM_SRC];
  strobe_t               strobes;
  ctrl_t                 gated;

  assign idSrc[0] = idRs;
  assign idSrc[1] = idRt;

  hazard_ctrl #(
    .REG_ADDR_W(REG_ADDR_W),
    .NUM_SRC   (NUM_SRC)
  ) u_ctrl (
    .exMemRead(exMemRead),
    .exRt     (exRt),
    .idSrc    (idSrc),
    .strobes  (strobes)
  );

  hazard_dp u_dp (
    .strobes  (strobes),
    .decCtrl  (ctrl_t'(decCtrl)),
    .pcWrite  (pcWrite),
    .ifidWrite(ifidWrite),
    .idexCtrl (gated)
  );

  assign idexCtrl = gated;
endmodule

// File: rtl/hazard_checker.sv
module hazard_checker
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input logic                  exMemRead,
  input logic [REG_ADDR_W-1:0] exRt,
  input logic [REG_ADDR_W-1:0] idRs,
  input logic [REG_ADDR_W-1:0] idRt,
  input logic [CTRL_W-1:0]     decCtrl,
  input logic                  pcWrite,
  input logic                  ifidWrite,
  input logic [CTRL_W-1:0]     idexCtrl
);
  always_comb begin
    if (exMemRead && exRt != '0 && exRt == idRs)
      assert_rs_stall_R1: assert (!pcWrite);
    if (exMemRead && exRt != '0 && exRt == idRt)
      assert_rt_stall_R2: assert (!pcWrite);
    if (!exMemRead)
      assert_no_load_R3: assert (pcWrite);
    if (exRt == '0)
      assert_zero_reg_R4: assert (pcWrite);
    assert_front_hold_R6: assert (pcWrite == ifidWrite);
    if (!pcWrite)
      assert_bubble_clear_R7: assert (idexCtrl == '0);
    if (pcWrite)
      assert_pass_through_R8: assert (idexCtrl == decCtrl);
  end
endmodule

bind load_use_hazard hazard_checker #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .exMemRead(exMemRead),
  .exRt     (exRt),
  .idRs     (idRs),
  .idRt     (idRt),
  .decCtrl  (decCtrl),
  .pcWrite  (pcWrite),
  .ifidWrite(ifidWrite),
  .idexCtrl (idexCtrl)
);

// File: tb/test_load_use_hazard.sv
`timescale 1ns/1ps
module test_load_use_hazard;
  localparam int AW = 5;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          exMemRead;
  logic [AW-1:0] exRt, idRs, idRt;
  logic [CW-1:0] decCtrl;
  logic          pcWrite, ifidWrite;
  logic [CW-1:0] idexCtrl;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  load_use_hazard #(.REG_ADDR_W(AW)) i_load_use_hazard (
    .exMemRead(exMemRead), .exRt(exRt), .idRs(idRs), .idRt(idRt),
    .decCtrl(decCtrl), .pcWrite(pcWrite), .ifidWrite(ifidWrite),
    .idexCtrl(idexCtrl)
  );

  function automatic logic expStall(logic mr, logic [AW-1:0] rt,
                                    logic [AW-1:0] rs, logic [AW-1:0] it);
    return mr && (rt != 0) && ((rt == rs) || (rt == it));
  endfunction

  task automatic check(string req, logic [CW-1:0] got, logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(logic mr, logic [AW-1:0] rt, logic [AW-1:0] rs,
                       logic [AW-1:0] it, logic [CW-1:0] c);
    @(posedge clk);
    #1;
    exMemRead = mr; exRt = rt; idRs = rs; idRt = it; decCtrl = c;
    @(negedge clk);
  endtask

  task automatic checkAll(string req);
    logic s;
    s = expStall(exMemRead, exRt, idRs, idRt);
    check({req, " pcWrite"},   {8'd0, pcWrite},   {8'd0, !s});
    check({req, " ifidWrite"}, {8'd0, ifidWrite}, {8'd0, !s});
    check({req, " idexCtrl"},  idexCtrl, s ? '0 : decCtrl);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CW-1:0] latched;
    void'($urandom(32'd1234));
    exMemRead = 0; exRt = 0; idRs = 0; idRt = 0; decCtrl = 0;
    @(negedge clk);
    check("R6 idle pcWrite", {8'd0, pcWrite}, 9'd1);

    drive(1, 5'd7, 5'd7, 5'd3, 9'h1FF); checkAll("R1 rs match");
    drive(1, 5'd9, 5'd2, 5'd9, 9'h0A5); checkAll("R2 rt match");
    drive(1, 5'd6, 5'd6, 5'd6, 9'h0FF); checkAll("R7 both match");
    check("R7 regWrite bit0", {8'd0, idexCtrl[0]}, 9'd0);
    check("R7 memWrite bit2", {8'd0, idexCtrl[2]}, 9'd0);
    drive(0, 5'd7, 5'd7, 5'd7, 9'h155); checkAll("R3 no load");
    check("R3 pcWrite", {8'd0, pcWrite}, 9'd1);
    drive(1, 5'd0, 5'd0, 5'd0, 9'h0AA); checkAll("R4 zero reg");
    check("R4 pcWrite", {8'd0, pcWrite}, 9'd1);
    drive(1, 5'd12, 5'd11, 5'd13, 9'h133); checkAll("R5 no match");
    check("R8 pass", idexCtrl, 9'h133);

    // R9: stall, then feed the bubble into EX and expect release
    drive(1, 5'd4, 5'd4, 5'd1, 9'h009);
    check("R9 first cycle stall", {8'd0, pcWrite}, 9'd0);
    latched = idexCtrl;
    drive(latched[3], 5'd4, 5'd4, 5'd1, 9'h009);
    check("R9 released next cycle", {8'd0, pcWrite}, 9'd1);
    check("R9 ctrl passes", idexCtrl, 9'h009);

    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 1), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            CW'($urandom));
      checkAll("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule